// File: doc/BRIEF.md
# Mode-Steered Four-Stage Shift/Load Register

This block is a small register chain whose behaviour is steered by a single mode bit. In shift mode, the stages move one place away from the first stage, and a serial bit enters the first stage. In load mode, every stage takes its own parallel input bit at once. Each mode has its own trigger input. The mode bit decides which trigger is allowed to reach the stages, and an edge on the other trigger does nothing.

Inside a larger chip, the whole block runs on one system clock. The two trigger inputs are sampled every cycle and act as edge-detected enable strobes. By default, the active edge is the rising edge: the strobe was low in the previous cycle and is high in the current one.

Shifting toward the first stage has no path of its own. The integrator gets it by wiring each stage output to the parallel input of the stage before it, wiring the serial source to the parallel input of the last stage, and issuing load strobes.

Top module: `mode_shift_reg`

## Requirements
- R1: While `rst` is high at a clock edge, all stages of `q` become 0 at that edge.
- R2: With `mode_sel`=1, a rising edge on `load_strobe` makes `q` equal to `par_in` at that clock edge. Bit i of `par_in` goes to stage i.
- R3: With `mode_sel`=0, a rising edge on `shift_strobe` moves stage i-1 into stage i, and `ser_in` into stage 0. Stage 0 is the first stage, so the pattern moves toward the last stage, `q[WIDTH-1]`.
- R4: A rising edge on `shift_strobe` while `mode_sel`=1 leaves `q` unchanged.
- R5: A rising edge on `load_strobe` while `mode_sel`=0 leaves `q` unchanged.
- R6: In a cycle with no rising edge on the selected strobe, `q` holds. A strobe held high acts only once.
- R7: When both strobes rise in the same cycle, only the operation picked by `mode_sel` takes place.
- R8: Shifting toward stage 0 works through the load path. With `par_in` = {`ser_in`, `q[WIDTH-1:1]`} and `mode_sel`=1, each load strobe moves stage i+1 into stage i and puts `ser_in` into the last stage.
- R9: A strobe that is already high while reset is released produces no operation after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 selects shifting, 1 selects parallel load |
| ser_in | input | 1 | Serial bit that enters stage 0 when shifting |
| par_in | input | WIDTH | Parallel load data; bit i goes to stage i |
| shift_strobe | input | 1 | Trigger for shift mode (acts on its active edge) |
| load_strobe | input | 1 | Trigger for load mode (acts on its active edge) |
| q | output | WIDTH | Stage outputs; q[0] is the first stage |

## Verification
The hardest case to reach from the ports is shifting toward stage 0, because no mode does it directly. The bench gets there by driving `par_in` combinationally from the outputs, {`ser_in`, `q[3:1]`}, and issuing load strobes. It compares each step against a model shifted the same way.

A second hard case is a strobe that never falls. The bench holds a strobe high across several clock cycles and also across a reset release, so that a level cannot be mistaken for a fresh edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } shreg_mode_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic strobe,
   output logic pulse
);
   logic prev_q;

   // Tracks the strobe through reset as well, so a level held across reset is no edge.
   always_ff @(posedge clk) begin
      prev_q <= strobe;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = strobe & ~prev_q;
      end else begin : g_fall
         assign pulse = ~strobe & prev_q;
      end
   endgenerate
endmodule

// File: rtl/mode_gate.sv
module mode_gate
   import shreg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic mode_sel,
   input  logic shift_pulse,
   input  logic load_pulse,
   output logic shift_en,
   output logic load_en
);
   shreg_mode_e mode;

   assign mode     = shreg_mode_e'(mode_sel);
   assign shift_en = shift_pulse & (mode == MODE_SHIFT);
   assign load_en  = load_pulse  & (mode == MODE_LOAD);

   // At most one operation reaches the stages in a cycle.
   p_one_op_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({shift_en, load_en}))
      else $error("both enables active");

   // A shift enable never occurs in load mode.
   p_shift_mode_r4: assert property (@(posedge clk) disable iff (rst)
      shift_en |-> !mode_sel)
      else $error("shift enabled in load mode");

   // A load enable never occurs in shift mode.
   p_load_mode_r5: assert property (@(posedge clk) disable iff (rst)
      load_en |-> mode_sel)
      else $error("load enabled in shift mode");
endmodule

// File: rtl/shift_stage.sv
module shift_stage (
   input  logic clk,
   input  logic rst,
   input  logic nbr_bit,
   input  logic par_bit,
   input  logic shift_en,
   input  logic load_en,
   output logic q
);
   logic d_next;

   always_comb begin
      d_next = q;
      if (shift_en) d_next = nbr_bit;
      if (load_en)  d_next = par_bit;
   end

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= d_next;
   end
endmodule

// File: rtl/mode_shift_reg.sv
module mode_shift_reg #(
   parameter int WIDTH        = 4,
   parameter bit RISING_EDGE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_sel,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   input  logic             shift_strobe,
   input  logic             load_strobe,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("WIDTH must be at least 2");
   end

   logic             shift_pulse, load_pulse;
   logic             shift_en, load_en;
   logic [WIDTH-1:0] nbr;

   strobe_edge #(.RISING(RISING_EDGE)) u_shift_edge (
      .clk(clk), .strobe(shift_strobe), .pulse(shift_pulse));

   strobe_edge #(.RISING(RISING_EDGE)) u_load_edge (
      .clk(clk), .strobe(load_strobe), .pulse(load_pulse));

   mode_gate u_gate (
      .clk(clk), .rst(rst), .mode_sel(mode_sel),
      .shift_pulse(shift_pulse), .load_pulse(load_pulse),
      .shift_en(shift_en), .load_en(load_en));

   assign nbr[0] = ser_in;

   generate
      for (genvar i = 1; i < WIDTH; i++) begin : g_link
         assign nbr[i] = q[i-1];
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         shift_stage u_stage (
            .clk(clk), .rst(rst),
            .nbr_bit(nbr[i]), .par_bit(par_in[i]),
            .shift_en(shift_en), .load_en(load_en),
            .q(q[i]));
      end
   endgenerate

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (q == '0))
      else $error("reset did not clear");

   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (q == $past(par_in)))
      else $error("load mismatch");

   p_shift_r3: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (q == {$past(q[LAST-1:0]), $past(ser_in)}))
      else $error("shift mismatch");

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!shift_en && !load_en) |=> $stable(q))
      else $error("register changed without an operation");
endmodule

// File: tb/tb_mode_shift_reg.sv
module tb_mode_shift_reg;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic         mode_sel, ser_in, shift_strobe, load_strobe;
   logic [W-1:0] par_reg, par_in, q;
   logic         wire_left;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   assign par_in = wire_left ? {ser_in, q[W-1:1]} : par_reg;

   mode_shift_reg #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_in(ser_in),
      .par_in(par_in), .shift_strobe(shift_strobe),
      .load_strobe(load_strobe), .q(q));

   // Vector: [11:10] op (0 none, 1 shift strobe, 2 load strobe, 3 both),
   // [9] mode, [8] ser, [7:4] par, [3:0] expected q after the strobe.
   localparam logic [11:0] VEC [12] = '{
      12'b10_1_0_1010_1010,   // R2 load
      12'b01_0_1_0000_0101,   // R3 shift in 1
      12'b01_0_0_0000_1010,   // R3
      12'b01_0_0_0000_0100,   // R3
      12'b01_1_0_1111_0100,   // R4 shift strobe in load mode
      12'b10_0_0_1111_0100,   // R5 load strobe in shift mode
      12'b11_0_1_0000_1001,   // R7 both, shift wins
      12'b11_1_0_0110_0110,   // R7 both, load wins
      12'b00_1_0_1111_0110,   // R6 no strobe
      12'b10_1_0_1111_1111,   // R2
      12'b01_0_0_0000_1110,   // R3
      12'b10_1_0_0000_0000    // R2 load zeros
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: q=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // One strobe operation: raise at negedge, acts at next posedge, drop at following negedge.
   task automatic pulse(input logic s, input logic l);
      shift_strobe = s;
      load_strobe  = l;
      @(negedge clk);
      shift_strobe = 1'b0;
      load_strobe  = 1'b0;
      @(negedge clk);
   endtask

   function automatic string tag_of(input logic [1:0] op, input logic m);
      if (op == 2'd0) return "R6";
      if (op == 2'd3) return "R7";
      if (op == 2'd1) return m ? "R4" : "R3";
      return m ? "R2" : "R5";
   endfunction

   initial begin
      #(8 * 20000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: q=%b expected completion", q);
      finish_run();
   end

   initial begin
      logic [W-1:0] model;
      rst = 1'b1; mode_sel = 1'b0; ser_in = 1'b0; par_reg = '0;
      shift_strobe = 1'b0; load_strobe = 1'b0; wire_left = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", q, '0);
      rst = 1'b0;
      @(negedge clk);

      foreach (VEC[k]) begin
         mode_sel = VEC[k][9];
         ser_in   = VEC[k][8];
         par_reg  = VEC[k][7:4];
         pulse(VEC[k][10], VEC[k][11]);
         check(tag_of(VEC[k][11:10], VEC[k][9]), q, VEC[k][3:0]);
      end

      // R6: strobe held high across several cycles acts once.
      mode_sel = 1'b0; ser_in = 1'b1;
      shift_strobe = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 held strobe", q, 4'b0001);
      shift_strobe = 1'b0;
      @(negedge clk);

      // R8: left shift through the load path, against a model.
      mode_sel = 1'b1; par_reg = 4'b1011;
      pulse(1'b0, 1'b1);
      check("R2 preload", q, 4'b1011);
      model = 4'b1011;
      wire_left = 1'b1;
      for (int s = 0; s < 6; s++) begin
         ser_in = s[0] ^ s[1];
         model = {ser_in, model[W-1:1]};
         pulse(1'b0, 1'b1);
         check("R8 left shift", q, model);
      end
      wire_left = 1'b0;

      // R1 again, with a nonzero register.
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset nonzero", q, '0);

      // R9: strobes high through reset release.
      mode_sel = 1'b0; ser_in = 1'b1; shift_strobe = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 level after reset", q, '0);
      shift_strobe = 1'b0;
      @(negedge clk);
      pulse(1'b1, 1'b0);
      check("R3 after reset", q, 4'b0001);

      finish_run();
   end
endmodule